// File: doc/BRIEF.md
# On-Screen Display Colour Overlay

This block sits in a multiplexed 4:2:2 YCbCr sample path and can replace samples with a colour from a small palette. Each sample arrives with a 2-bit tag that says which component it carries. The tags follow a repeating cycle: Cb, first Y, Cr, second Y. The block passes the stream through one register stage. When the overlay enable is high for a sample, the block outputs the matching component of the selected palette colour instead of the input sample.

The palette holds eight colours. Each colour keeps only the upper four bits of Y, Cb and Cr, which is 12 bits per colour. The eight colours are packed into twelve byte-wide registers, written through a simple address/data port. The enable and the 3-bit colour select are taken on the same edge as the sample they apply to. This means the overlay window can be as small as one sample or as large as a whole frame, and it can have a different width on each line. Substituted samples have their low bits cleared and are kept inside the legal code range, so they can never produce a timing-reference code.

Top module: `osd_overlay`

## Requirements
- R1: A synchronous active-low reset clears the output to 0x00 and clears all twelve palette bytes to 0x00. The output stays at 0x00 while reset is held.
- R2: A write with `pal_wr_en` high and `pal_wr_addr` in the range 0 to 11 stores `pal_wr_data` into that byte. A write to addresses 12 to 15 changes no palette byte.
- R3: Colour k starts at byte b = floor(3k/2). For even k, Y is the high nibble of byte b, Cb is the low nibble of byte b, and Cr is the high nibble of byte b+1. For odd k, Y is the low nibble of byte b, Cb is the high nibble of byte b+1, and Cr is the low nibble of byte b+1.
- R4: The phase tag selects the component that is substituted. A tag of 0 takes Cb, a tag of 2 takes Cr, and tags 1 and 3 take Y.
- R5: A substituted sample is the palette nibble placed in bits 7:4, with bits 3:0 set to zero.
- R6: A substituted value of 0x00 is output as 0x01. A substituted sample is never 0x00 or 0xFF.
- R7: While `osd_en` is low, the output is the input sample unchanged, including the values 0x00 and 0xFF.
- R8: Every sample, substituted or not, appears at the output exactly one clock after it is presented. `osd_en` and `osd_sel` act on the sample presented in the same cycle, so a window one sample wide affects only that sample.
- R9: If a palette write and a substitution that uses the same byte fall in the same cycle, the substitution uses the value the byte held before the write. The new value is used from the next sample onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_in | input | 8 | Multiplexed input sample |
| pix_phase | input | 2 | Component tag of `pix_in` (0 Cb, 1 Y, 2 Cr, 3 Y) |
| osd_sel | input | 3 | Palette colour select |
| osd_en | input | 1 | Replace this sample with the palette colour |
| pal_wr_en | input | 1 | Palette byte write strobe |
| pal_wr_addr | input | 4 | Palette byte index |
| pal_wr_data | input | 8 | Palette byte value |
| pix_out | output | 8 | Output sample, one clock after input |

## Verification
A palette write and an overlay substitution that reads the same palette byte can fall in the same cycle. The bench provokes this by writing byte 0 while colour 0 is being substituted on a Y sample. It expects the old nibble on that sample and the new nibble on the next one. A second case where two behaviours meet is a substituted nibble of zero: placing the nibble and clamping it happen in the same cycle. The bench programs colours whose Y and Cb nibbles are zero and expects 0x01 at the output.

// File: rtl/osd_overlay_pkg.sv
// Package: osd_overlay_pkg
// Types shared by the colour overlay blocks.
// Assumes the tag cycle Cb, Y, Cr, Y on the multiplexed sample stream.
package osd_overlay_pkg;

    // Component tag carried with every sample
    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } comp_phase_e;

endpackage

// File: rtl/osd_palette.sv
// Module: osd_palette
// Bank of byte-wide palette registers, written through one address/data port.
// Assumes: addresses at or above NUM_REGS are dropped; all bytes are cleared by reset.
// The bank is shown flat so that a combinational reader sees the value before any write.
module osd_palette #(
    parameter int NUM_REGS = 12,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] bank_flat
);

    localparam int BANK_W = NUM_REGS * DATA_W;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_byte
            logic [DATA_W-1:0] byte_q;

            // Hold one palette byte; load it when its index is written
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    byte_q <= '0;
                end else if (wr_en && (wr_addr == ADDR_W'(gi))) begin
                    byte_q <= wr_data;
                end
            end

            assign bank_flat[gi*DATA_W +: DATA_W] = byte_q;
        end
    endgenerate

    // R2
    oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) >= NUM_REGS)) |=> $stable(bank_flat));

    // R2
    write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) < NUM_REGS)) |=>
        (bank_flat[int'($past(wr_addr))*DATA_W +: DATA_W] == $past(wr_data)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        (!rst_n) |=> (bank_flat == {BANK_W{1'b0}}));

endmodule

// File: rtl/osd_color_pick.sv
// Module: osd_color_pick
// Unpacks every palette colour from the packed byte bank and selects one of them.
// Assumes: colour k starts at byte floor(3k/2). Even colours take the whole first
// byte plus the high nibble of the next byte; odd colours take the low nibble of the
// shared byte plus the whole next byte. Purely combinational.
module osd_color_pick #(
    parameter int SEL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic [((1<<SEL_W)*3/2)*DATA_W-1:0] bank_flat,
    input  logic [SEL_W-1:0]                   sel,
    output logic [DATA_W/2-1:0]                y_nib,
    output logic [DATA_W/2-1:0]                cb_nib,
    output logic [DATA_W/2-1:0]                cr_nib
);

    localparam int NUM_COLORS = 1 << SEL_W;
    localparam int NIB_W      = DATA_W / 2;

    logic [NIB_W-1:0] pal_y  [NUM_COLORS];
    logic [NIB_W-1:0] pal_cb [NUM_COLORS];
    logic [NIB_W-1:0] pal_cr [NUM_COLORS];

    genvar gk;
    generate
        for (gk = 0; gk < NUM_COLORS; gk++) begin : g_color
            localparam int BASE = (3 * gk) / 2;
            logic [DATA_W-1:0] first_b;
            logic [DATA_W-1:0] second_b;

            assign first_b  = bank_flat[BASE*DATA_W +: DATA_W];
            assign second_b = bank_flat[(BASE+1)*DATA_W +: DATA_W];

            if ((gk % 2) == 0) begin : g_even
                assign pal_y[gk]  = first_b[DATA_W-1:NIB_W];
                assign pal_cb[gk] = first_b[NIB_W-1:0];
                assign pal_cr[gk] = second_b[DATA_W-1:NIB_W];
            end else begin : g_odd
                assign pal_y[gk]  = first_b[NIB_W-1:0];
                assign pal_cb[gk] = second_b[DATA_W-1:NIB_W];
                assign pal_cr[gk] = second_b[NIB_W-1:0];
            end
        end
    endgenerate

    // Route the selected colour's three nibbles out
    always_comb begin
        y_nib  = pal_y[sel];
        cb_nib = pal_cb[sel];
        cr_nib = pal_cr[sel];
    end

endmodule

// File: rtl/osd_sample_mux.sv
// Module: osd_sample_mux
// Chooses, for each sample, between the input and the palette component that
// matches its tag, and registers the result. Both paths have one register stage.
// Assumes: the palette nibble becomes the upper half of the sample and the lower
// half is zero; the result is held inside [1, 2^DATA_W - 2].
module osd_sample_mux
    import osd_overlay_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   pix_in,
    input  comp_phase_e         phase,
    input  logic                ovl_en,
    input  logic [DATA_W/2-1:0] y_nib,
    input  logic [DATA_W/2-1:0] cb_nib,
    input  logic [DATA_W/2-1:0] cr_nib,
    output logic [DATA_W-1:0]   pix_out
);

    localparam int              NIB_W  = DATA_W / 2;
    localparam logic [DATA_W-1:0] LO_LIM = DATA_W'(1);
    localparam logic [DATA_W-1:0] HI_LIM = {DATA_W{1'b1}} - DATA_W'(1);

    logic [NIB_W-1:0]  comp_nib;
    logic [DATA_W-1:0] widened;
    logic [DATA_W-1:0] clamped;

    // Pick the palette component that matches the sample's tag
    always_comb begin
        unique case (phase)
            PH_CB:   comp_nib = cb_nib;
            PH_CR:   comp_nib = cr_nib;
            default: comp_nib = y_nib;
        endcase
    end

    // Widen the nibble and keep it off the reserved end codes
    always_comb begin
        widened = {comp_nib, {NIB_W{1'b0}}};
        if (widened < LO_LIM) begin
            clamped = LO_LIM;
        end else if (widened > HI_LIM) begin
            clamped = HI_LIM;
        end else begin
            clamped = widened;
        end
    end

    // Output register: substitute or pass the sample through
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out <= '0;
        end else if (ovl_en) begin
            pix_out <= clamped;
        end else begin
            pix_out <= pix_in;
        end
    end

    // R7
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovl_en) |=> (pix_out == $past(pix_in)));

    // R5
    nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_en |=> ((pix_out[NIB_W-1:0] == '0) || (pix_out == LO_LIM)));

    // R6
    clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_en |=> ((pix_out != '0) && (pix_out != {DATA_W{1'b1}})));

    // R1
    reset_out_chk: assert property (@(posedge clk)
        (!rst_n) |=> (pix_out == '0));

endmodule

// File: rtl/osd_overlay.sv
// Module: osd_overlay
// Top of the colour overlay: palette bank, colour unpacking and the sample mux.
// Assumes: the sample, its tag, the enable and the select arrive together and
// are acted on at the same edge; palette writes show up one clock later.
module osd_overlay
    import osd_overlay_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int DATA_W = 8,
    parameter int ADDR_W = $clog2(((1 << SEL_W) * 3) / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_in,
    input  logic [1:0]        pix_phase,
    input  logic [SEL_W-1:0]  osd_sel,
    input  logic              osd_en,
    input  logic              pal_wr_en,
    input  logic [ADDR_W-1:0] pal_wr_addr,
    input  logic [DATA_W-1:0] pal_wr_data,
    output logic [DATA_W-1:0] pix_out
);

    localparam int NUM_COLORS = 1 << SEL_W;
    localparam int NUM_REGS   = (NUM_COLORS * 3) / 2;
    localparam int NIB_W      = DATA_W / 2;

    logic [NUM_REGS*DATA_W-1:0] bank_flat;
    logic [NIB_W-1:0]           y_nib;
    logic [NIB_W-1:0]           cb_nib;
    logic [NIB_W-1:0]           cr_nib;
    comp_phase_e                phase;

    // Give the raw tag its enumerated meaning
    always_comb phase = comp_phase_e'(pix_phase);

    osd_palette #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) i_palette (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (pal_wr_en),
        .wr_addr   (pal_wr_addr),
        .wr_data   (pal_wr_data),
        .bank_flat (bank_flat)
    );

    osd_color_pick #(
        .SEL_W  (SEL_W),
        .DATA_W (DATA_W)
    ) i_pick (
        .bank_flat (bank_flat),
        .sel       (osd_sel),
        .y_nib     (y_nib),
        .cb_nib    (cb_nib),
        .cr_nib    (cr_nib)
    );

    osd_sample_mux #(
        .DATA_W (DATA_W)
    ) i_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_in  (pix_in),
        .phase   (phase),
        .ovl_en  (osd_en),
        .y_nib   (y_nib),
        .cb_nib  (cb_nib),
        .cr_nib  (cr_nib),
        .pix_out (pix_out)
    );

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osd_en && !$isunknown(pix_in)) |=> (pix_out == $past(pix_in)));

endmodule

// File: tb/test_osd_overlay.sv
module test_osd_overlay;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pix_in = 8'h00;
    logic [1:0] pix_phase = 2'd0;
    logic [2:0] osd_sel = 3'd0;
    logic       osd_en = 1'b0;
    logic       pal_wr_en = 1'b0;
    logic [3:0] pal_wr_addr = 4'd0;
    logic [7:0] pal_wr_data = 8'h00;
    logic [7:0] pix_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    osd_overlay i_osd_overlay (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_in      (pix_in),
        .pix_phase   (pix_phase),
        .osd_sel     (osd_sel),
        .osd_en      (osd_en),
        .pal_wr_en   (pal_wr_en),
        .pal_wr_addr (pal_wr_addr),
        .pal_wr_data (pal_wr_data),
        .pix_out     (pix_out)
    );

    // Palette contents written at start
    localparam logic [7:0] PAL [12] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC,
                                        8'hDE, 8'hF0, 8'h0F, 8'h00, 8'hA5, 8'hFF};
    // Expected colours {Y, Cb, Cr} from the packing rule (R3) and clamp (R6)
    localparam logic [23:0] COLS [8] = '{
        {8'h10, 8'h20, 8'h30}, {8'h40, 8'h50, 8'h60},
        {8'h70, 8'h80, 8'h90}, {8'hA0, 8'hB0, 8'hC0},
        {8'hD0, 8'hE0, 8'hF0}, {8'h01, 8'h01, 8'hF0},
        {8'h01, 8'h01, 8'hA0}, {8'h50, 8'hF0, 8'hF0}};

    // Vector: {phase[21:20], sel[19:17], en[16], pix[15:8], expected[7:0]}
    localparam int NV = 34;
    localparam logic [21:0] VEC [NV] = '{
        {2'd0, 3'd0, 1'b0, 8'h80, 8'h80},
        {2'd1, 3'd0, 1'b0, 8'hEB, 8'hEB},
        {2'd0, 3'd0, 1'b1, 8'h80, 8'h20},
        {2'd1, 3'd0, 1'b1, 8'h80, 8'h10},
        {2'd2, 3'd0, 1'b1, 8'h80, 8'h30},
        {2'd3, 3'd0, 1'b1, 8'h80, 8'h10},
        {2'd0, 3'd1, 1'b1, 8'h11, 8'h50},
        {2'd1, 3'd1, 1'b1, 8'h11, 8'h40},
        {2'd2, 3'd1, 1'b1, 8'h11, 8'h60},
        {2'd1, 3'd2, 1'b1, 8'h22, 8'h70},
        {2'd0, 3'd2, 1'b1, 8'h22, 8'h80},
        {2'd2, 3'd2, 1'b1, 8'h22, 8'h90},
        {2'd1, 3'd3, 1'b1, 8'h22, 8'hA0},
        {2'd0, 3'd3, 1'b1, 8'h22, 8'hB0},
        {2'd2, 3'd3, 1'b1, 8'h22, 8'hC0},
        {2'd1, 3'd4, 1'b1, 8'h22, 8'hD0},
        {2'd0, 3'd4, 1'b1, 8'h22, 8'hE0},
        {2'd2, 3'd4, 1'b1, 8'h22, 8'hF0},
        {2'd1, 3'd5, 1'b1, 8'h22, 8'h01},
        {2'd0, 3'd5, 1'b1, 8'h22, 8'h01},
        {2'd2, 3'd5, 1'b1, 8'h22, 8'hF0},
        {2'd1, 3'd6, 1'b1, 8'h22, 8'h01},
        {2'd0, 3'd6, 1'b1, 8'h22, 8'h01},
        {2'd2, 3'd6, 1'b1, 8'h22, 8'hA0},
        {2'd1, 3'd7, 1'b1, 8'h22, 8'h50},
        {2'd0, 3'd7, 1'b1, 8'h22, 8'hF0},
        {2'd3, 3'd7, 1'b1, 8'h22, 8'h50},
        {2'd2, 3'd7, 1'b1, 8'h22, 8'hF0},
        {2'd0, 3'd7, 1'b0, 8'h33, 8'h33},
        {2'd1, 3'd7, 1'b1, 8'h33, 8'h50},
        {2'd2, 3'd7, 1'b0, 8'h44, 8'h44},
        {2'd1, 3'd0, 1'b0, 8'h00, 8'h00},
        {2'd0, 3'd0, 1'b0, 8'hFF, 8'hFF},
        {2'd3, 3'd0, 1'b0, 8'h7E, 8'h7E}};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        pal_wr_en = 1'b1; pal_wr_addr = a; pal_wr_data = d;
        @(negedge clk);
        pal_wr_en = 1'b0;
    endtask

    // Substitute all three components of colour k and compare (R2, R3)
    task automatic check_color(input int k, input string req);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            osd_en = 1'b1; osd_sel = 3'(k); pix_in = 8'h66;
            pix_phase = (c == 0) ? 2'd1 : (c == 1) ? 2'd0 : 2'd2;
            @(negedge clk);
            check(req, pix_out, COLS[k][23-8*c -: 8]);
        end
        osd_en = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, input ignored while reset held
        pix_in = 8'hAA; osd_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset output", pix_out, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++) write_byte(4'(i), PAL[i]);

        // Vector table: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pix_phase = VEC[v][21:20];
            osd_sel   = VEC[v][19:17];
            osd_en    = VEC[v][16];
            pix_in    = VEC[v][15:8];
            @(negedge clk);
            if (VEC[v][7:0] == 8'h01)
                check($sformatf("R6 clamp vec %0d", v), pix_out, VEC[v][7:0]);
            else if (VEC[v][16])
                check($sformatf("R3 R4 R5 R8 vec %0d", v), pix_out, VEC[v][7:0]);
            else
                check($sformatf("R7 R8 vec %0d", v), pix_out, VEC[v][7:0]);
        end
        osd_en = 1'b0;

        // R2: writes beyond byte 11 leave every colour intact
        for (int a = 12; a < 16; a++) write_byte(4'(a), 8'h00);
        for (int k = 0; k < 8; k++) check_color(k, "R2 out-of-range write");

        // R9: write byte 0 while colour 0 is being substituted
        @(negedge clk);
        pal_wr_en = 1'b1; pal_wr_addr = 4'd0; pal_wr_data = 8'h9C;
        osd_en = 1'b1; osd_sel = 3'd0; pix_phase = 2'd1; pix_in = 8'h55;
        @(negedge clk);
        check("R9 old value on write cycle", pix_out, 8'h10);
        pal_wr_en = 1'b0;
        @(negedge clk);
        check("R9 new value next sample", pix_out, 8'h90);
        pix_phase = 2'd0;
        @(negedge clk);
        check("R2 R9 new Cb", pix_out, 8'hC0);
        osd_en = 1'b0;

        // R1: reset mid-run clears output and palette
        @(negedge clk);
        rst_n = 1'b0; pix_in = 8'h77;
        @(negedge clk);
        check("R1 output in reset", pix_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        osd_en = 1'b1; osd_sel = 3'd0; pix_phase = 2'd1;
        @(negedge clk);
        check("R1 R6 cleared palette Y", pix_out, 8'h01);
        osd_sel = 3'd7; pix_phase = 2'd2;
        @(negedge clk);
        check("R1 R6 cleared palette Cr", pix_out, 8'h01);
        osd_en = 1'b0;

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule